// File: doc/BRIEF.md
# Two-Street Crossing Light Sequencer

This block sequences the lamps at a crossing of two streets, A and B. Each street has one presence sensor, which reads high while traffic waits on or moves along it. The block is a Moore machine with four phases. Street A keeps its green for as long as its sensor stays high. When that sensor drops, A shows yellow for exactly one clock cycle, and then B turns green. Street B follows the same rules, and after B's single yellow cycle the machine returns to A green.

Both lamp outputs are decoded from the registered phase only. A change on a sensor therefore reaches the lamps no sooner than the next rising clock edge. Reset is synchronous and active high, and it selects A green with B red. A build parameter chooses how the phase is stored, either as a 2-bit binary code or as a 4-bit one-hot word. Both forms give the same lamp sequence.

Top module: `tlc_crossing`

## Requirements
- R1: A clock edge with `rst` high puts the block in A-green. From the next edge on, `lamp_a` = 00 (green) and `lamp_b` = 10 (red). Lamp codes are green 00, yellow 01 and red 10.
- R2: In A-green with `sense_a` high, the next edge keeps A-green. `sense_b` has no effect in this phase.
- R3: In A-green with `sense_a` low, the next edge moves to A-yellow: `lamp_a` = 01, `lamp_b` = 10.
- R4: A-yellow lasts exactly one cycle. The next edge always moves to B-green (`lamp_a` = 10, `lamp_b` = 00), whatever the sensor values.
- R5: In B-green with `sense_b` high, the next edge keeps B-green. `sense_a` has no effect in this phase.
- R6: In B-green with `sense_b` low, the next edge moves to B-yellow: `lamp_a` = 10, `lamp_b` = 01.
- R7: B-yellow lasts exactly one cycle. The next edge always returns to A-green, whatever the sensor values.
- R8: Code 11 never appears on either lamp output, and in every cycle at least one of the two lamps shows red.
- R9: A change on the sensors between clock edges leaves both lamp outputs unchanged until the next rising edge.
- R10: The binary (`ONE_HOT` = 0) and one-hot (`ONE_HOT` = 1) storage variants produce identical lamp outputs for the same stimulus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to A-green |
| sense_a | input | 1 | Street A presence sensor, high while traffic is present |
| sense_b | input | 1 | Street B presence sensor, high while traffic is present |
| lamp_a | output | 2 | Street A lamp code (00 green, 01 yellow, 10 red) |
| lamp_b | output | 2 | Street B lamp code (00 green, 01 yellow, 10 red) |

## Verification
The bench builds two copies side by side, one with `ONE_HOT` = 0 and one with `ONE_HOT` = 1, and drives both with the same stimulus. This makes any difference between the storage forms visible every cycle. The sensor stimulus is biased toward high, so green phases are held for several cycles, and across the run every phase meets all four sensor combinations. That covers each hold, each exit and each ignored sensor. A reset in the middle of the run, and sensor changes between clock edges, exercise the recovery to A-green and the absence of any path from the sensors to the lamps.

// File: rtl/tlc_pkg.sv
package tlc_pkg;

    localparam int PHASE_W = 2;
    localparam int LAMP_W  = 2;
    localparam int N_PHASE = 4;

    typedef enum logic [PHASE_W-1:0] {
        PH_A_GO   = 2'b00,
        PH_A_WARN = 2'b01,
        PH_B_GO   = 2'b10,
        PH_B_WARN = 2'b11
    } phase_t;

    typedef enum logic [LAMP_W-1:0] {
        LAMP_GREEN  = 2'b00,
        LAMP_YELLOW = 2'b01,
        LAMP_RED    = 2'b10
    } lamp_t;

endpackage

// File: rtl/tlc_next.sv
module tlc_next
    import tlc_pkg::*;
(
    input  phase_t phase_q,
    input  logic   sense_a,
    input  logic   sense_b,
    output phase_t phase_nx
);
    always_comb begin
        phase_nx = phase_q;
        unique case (phase_q)
            PH_A_GO:   phase_nx = sense_a ? PH_A_GO : PH_A_WARN;
            PH_A_WARN: phase_nx = PH_B_GO;
            PH_B_GO:   phase_nx = sense_b ? PH_B_GO : PH_B_WARN;
            PH_B_WARN: phase_nx = PH_A_GO;
            default:   phase_nx = PH_A_GO;
        endcase
    end
endmodule

// File: rtl/tlc_state_reg.sv
module tlc_state_reg
    import tlc_pkg::*;
#(
    parameter bit ONE_HOT = 1'b0
) (
    input  logic   clk,
    input  logic   rst,
    input  phase_t phase_nx,
    output phase_t phase_q
);
    generate
        if (ONE_HOT) begin : g_hot
            typedef struct packed {
                logic [N_PHASE-1:0] hot;
            } hot_st_t;

            hot_st_t st_d, st_q;

            always_comb begin
                st_d = st_q;
                if (rst) st_d.hot = N_PHASE'(1);
                else     st_d.hot = N_PHASE'(1) << phase_nx;
            end

            always_ff @(posedge clk) begin
                st_q <= st_d;
            end

            always_comb begin
                logic [PHASE_W-1:0] acc;
                acc = '0;
                for (int i = 0; i < N_PHASE; i++) begin
                    if (st_q.hot[i]) acc = acc | PHASE_W'(i);
                end
                phase_q = phase_t'(acc);
            end
        end else begin : g_bin
            typedef struct packed {
                phase_t ph;
            } bin_st_t;

            bin_st_t st_d, st_q;

            always_comb begin
                st_d = st_q;
                if (rst) st_d.ph = PH_A_GO;
                else     st_d.ph = phase_nx;
            end

            always_ff @(posedge clk) begin
                st_q <= st_d;
            end

            assign phase_q = st_q.ph;
        end
    endgenerate
endmodule

// File: rtl/tlc_lamp_dec.sv
module tlc_lamp_dec
    import tlc_pkg::*;
(
    input  phase_t phase_q,
    output lamp_t  lamp_a,
    output lamp_t  lamp_b
);
    always_comb begin
        lamp_a = LAMP_RED;
        lamp_b = LAMP_RED;
        unique case (phase_q)
            PH_A_GO:   lamp_a = LAMP_GREEN;
            PH_A_WARN: lamp_a = LAMP_YELLOW;
            PH_B_GO:   lamp_b = LAMP_GREEN;
            PH_B_WARN: lamp_b = LAMP_YELLOW;
            default: begin
                lamp_a = LAMP_RED;
                lamp_b = LAMP_RED;
            end
        endcase
    end
endmodule

// File: rtl/tlc_crossing.sv
module tlc_crossing
    import tlc_pkg::*;
#(
    parameter bit ONE_HOT = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sense_a,
    input  logic              sense_b,
    output logic [LAMP_W-1:0] lamp_a,
    output logic [LAMP_W-1:0] lamp_b
);
    phase_t phase_q;
    phase_t phase_nx;
    lamp_t  la;
    lamp_t  lb;

    tlc_next u_next (
        .phase_q  (phase_q),
        .sense_a  (sense_a),
        .sense_b  (sense_b),
        .phase_nx (phase_nx)
    );

    tlc_state_reg #(.ONE_HOT(ONE_HOT)) u_state (
        .clk      (clk),
        .rst      (rst),
        .phase_nx (phase_nx),
        .phase_q  (phase_q)
    );

    tlc_lamp_dec u_dec (
        .phase_q (phase_q),
        .lamp_a  (la),
        .lamp_b  (lb)
    );

    assign lamp_a = la;
    assign lamp_b = lb;
endmodule

// File: rtl/tlc_crossing_chk.sv
module tlc_crossing_chk (
    input logic       clk,
    input logic       rst,
    input logic       sense_a,
    input logic       sense_b,
    input logic [1:0] lamp_a,
    input logic [1:0] lamp_b
);
    localparam logic [1:0] GRN = 2'b00;
    localparam logic [1:0] YEL = 2'b01;
    localparam logic [1:0] RED = 2'b10;

    logic seen_q;
    always_ff @(posedge clk) seen_q <= 1'b1;

    AST_RESET_A_GREEN: assert property (@(posedge clk) disable iff (rst)
        (seen_q && $past(rst)) |-> (lamp_a == GRN && lamp_b == RED)); // R1
    AST_HOLD_A: assert property (@(posedge clk) disable iff (rst)
        (lamp_a == GRN && sense_a) |=> (lamp_a == GRN && lamp_b == RED)); // R2
    AST_A_TO_YELLOW: assert property (@(posedge clk) disable iff (rst)
        (lamp_a == GRN && !sense_a) |=> (lamp_a == YEL && lamp_b == RED)); // R3
    AST_A_YELLOW_ONCE: assert property (@(posedge clk) disable iff (rst)
        (lamp_a == YEL) |=> (lamp_a == RED && lamp_b == GRN)); // R4
    AST_HOLD_B: assert property (@(posedge clk) disable iff (rst)
        (lamp_b == GRN && sense_b) |=> (lamp_b == GRN && lamp_a == RED)); // R5
    AST_B_TO_YELLOW: assert property (@(posedge clk) disable iff (rst)
        (lamp_b == GRN && !sense_b) |=> (lamp_b == YEL && lamp_a == RED)); // R6
    AST_B_YELLOW_ONCE: assert property (@(posedge clk) disable iff (rst)
        (lamp_b == YEL) |=> (lamp_a == GRN && lamp_b == RED)); // R7
    AST_NO_CODE3: assert property (@(posedge clk) disable iff (rst)
        (lamp_a != 2'b11 && lamp_b != 2'b11)); // R8
    AST_ONE_RED: assert property (@(posedge clk) disable iff (rst)
        (lamp_a == RED || lamp_b == RED)); // R8
endmodule

bind tlc_crossing tlc_crossing_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .sense_a (sense_a),
    .sense_b (sense_b),
    .lamp_a  (lamp_a),
    .lamp_b  (lamp_b)
);

// File: tb/sim_tlc_crossing.sv
`timescale 1ns/1ps
module sim_tlc_crossing;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sa  = 1'b0;
    logic sb  = 1'b0;
    logic [1:0] la0, lb0, la1, lb1;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    tlc_crossing #(.ONE_HOT(1'b0)) u0 (
        .clk(clk), .rst(rst), .sense_a(sa), .sense_b(sb), .lamp_a(la0), .lamp_b(lb0));
    tlc_crossing #(.ONE_HOT(1'b1)) u1 (
        .clk(clk), .rst(rst), .sense_a(sa), .sense_b(sb), .lamp_a(la1), .lamp_b(lb1));

    function automatic logic [1:0] exp_a(int m);
        return (m == 0) ? 2'b00 : (m == 1) ? 2'b01 : 2'b10;
    endfunction
    function automatic logic [1:0] exp_b(int m);
        return (m == 2) ? 2'b00 : (m == 3) ? 2'b01 : 2'b10;
    endfunction

    task automatic chk(string req, logic [1:0] act, logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_bit(string req, bit ok, logic [3:0] act);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%b expected=legal pair at %0t", req, act, $time);
        end
    endtask

    initial begin
        int model;
        string tag;
        logic [15:0] lfsr;
        logic [1:0] hold_a, hold_b;
        lfsr = 16'hACE1;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 lamp_a", la0, 2'b00);
        chk("R1 lamp_b", lb0, 2'b10);
        chk("R1 lamp_a onehot", la1, 2'b00);
        rst = 1'b0;
        model = 0;
        tag = "R1";
        for (int i = 0; i < 3000; i++) begin
            chk({tag, " lamp_a"}, la0, exp_a(model));
            chk({tag, " lamp_b"}, lb0, exp_b(model));
            chk("R10 lamp_a variants", la1, la0);
            chk("R10 lamp_b variants", lb1, lb0);
            chk_bit("R8 legal codes", la0 != 2'b11 && lb0 != 2'b11 &&
                    (la0 == 2'b10 || lb0 == 2'b10), {la0, lb0});
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (i < 1500) begin
                sa = (lfsr[1:0] != 2'b00);
                sb = (lfsr[3:2] != 2'b00);
            end else begin
                sa = lfsr[0];
                sb = lfsr[5];
            end
            rst = (i == 1200 || i == 2400);
            hold_a = la0;
            hold_b = lb0;
            #1;
            // R9: sensors changed mid-cycle, lamps must not move
            chk("R9 lamp_a stable", la0, hold_a);
            chk("R9 lamp_b stable", lb0, hold_b);
            if (rst) begin
                model = 0; tag = "R1";
            end else begin
                case (model)
                    0: if (sa) tag = "R2"; else begin model = 1; tag = "R3"; end
                    1: begin model = 2; tag = "R4"; end
                    2: if (sb) tag = "R5"; else begin model = 3; tag = "R6"; end
                    default: begin model = 0; tag = "R7"; end
                endcase
            end
            @(negedge clk);
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule